// File: doc/BRIEF.md
# Single-Word SPI Master with Register Port

This block is an SPI master that moves one word per operation. Software reaches it through a plain 16-bit register port. It sets up the serial clock rate, the sampling edge, the chip-select polarity and the interrupt style in two configuration registers, then loads the transmit halves. A write to the control register then starts either a write-only or a read-only word of 4 to 32 bits, addressed to one of the chip-select slots. When the word is finished, a per-direction completion flag in the status register is set. Software can poll that flag or take it as an interrupt.

Words of eight bits or fewer always go out as 16-bit frames. Bits leave from the top of the 32-bit transmit pair, so a short word placed in the upper byte of the high transmit half is sent first, followed by zero padding. Received bits enter the bottom of the 32-bit receive pair, so a 16-bit read lands entirely in the low receive half. The serial clock only runs while the clock-enable bit is set. Clearing that bit freezes a word in progress.

Top module: `spi_word_master`

## Requirements
- R1: After reset every register reads zero, `irq` is 0, both `spi_cs` lines are high (inactive for the default low-active polarity), and `spi_sclk` is high (the idle level when falling-edge sampling is selected).
- R2: The register index is `reg_addr[3:1]`, with 0 = config A, 1 = config B, 2 = control, 3 = status, 4 = TX low, 5 = TX high, 6 = RX low and 7 = RX high. Config A holds clock enable (bit 0), divisor (bits 3:1), write-done interrupt enable (bit 4) and read-done interrupt enable (bit 5). Config B holds the sampling edge (bit 0, 1 = rising), the chip-select active level (bit 5, 1 = high) and the interrupt style (bit 10, 1 = pulse). Unused bits read 0.
- R3: A control write with bit 1 set and bit 0 clear starts a write. The frame length L is the length field (bits 6:2) plus one, or 16 when that sum is 8 or less. `spi_mosi` carries bits 31 down to 32-L of {TX high, TX low}, most significant bit first.
- R4: A control write with bit 0 set starts a read of L bits, with L as in R3. The receive pair is cleared at the start, and each sampled `spi_miso` bit enters at bit 0. After the read, {RX high, RX low} holds the L received bits right-justified.
- R5: Sampling edges of `spi_sclk` are 2^(divisor+1) clock cycles apart. The idle level is the inverse of the edge bit. Each bit is sampled on the first transition away from idle and shifted out on the return.
- R6: While clock enable is 0, `spi_sclk` does not toggle and a started word does not advance. Setting the bit lets the word continue to completion.
- R7: During a word, only the chip-select line picked by control bit 7 sits at the active level. All lines sit at the inactive level otherwise.
- R8: At the end of a write, status bit 1 sets, and at the end of a read, status bit 0 sets. A write to the status register ANDs the stored bits with the written data, so writing 0 clears both.
- R9: A control write while a word is in progress is ignored. The control register reads back the slot in bit 7 and the length field in bits 6:2, and bits 1:0 always read 0.
- R10: `irq` is the OR of each status bit ANDed with its enable. In pulse style it is high for exactly one cycle each time that OR rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip selects, polarity per config B |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps every word length from 4 to 32 in both directions, rotating the divisor, the sampling edge, the slot and the chip-select polarity. Its slave model counts sampling edges and compares the captured and returned bits with arithmetic slices of the words. A design that skipped the 16-bit padding for short words would show too few edges. One that shifted from the wrong end would send the zero padding first or leave a read left-justified. Further tests freeze a word by clearing the clock enable, fire a second control write into a busy word, which must not change the length or start a second word, clear one status bit while keeping the other, and count `irq` cycles in pulse style, where a level output would be caught by a count above one.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int DATA_W  = 16;
    localparam int FRAME_W = 2 * DATA_W;
    localparam int DIV_W   = 3;
    localparam int LEN_W   = 5;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int SLOT_LSB = 7;

    typedef enum logic [2:0] {
        SEL_CFGA = 3'd0,
        SEL_CFGB = 3'd1,
        SEL_CTRL = 3'd2,
        SEL_STAT = 3'd3,
        SEL_TXL  = 3'd4,
        SEL_TXH  = 3'd5,
        SEL_RXL  = 3'd6,
        SEL_RXH  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic             ie_rd;
        logic             ie_wr;
        logic [DIV_W-1:0] div;
        logic             clk_en;
    } cfga_t;

    typedef struct packed {
        logic pulse_irq;
        logic cs_high;
        logic rise;
    } cfgb_t;

    // Short words are stretched to a 16-bit frame.
    function automatic logic [CNT_W-1:0] frame_bits(logic [LEN_W-1:0] len_m1);
        return (len_m1 < LEN_W'(8)) ? CNT_W'(16) : CNT_W'(len_m1) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/spw_tick.sv
module spw_tick #(
    parameter int DIV_W = spw_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((32'd1 << div) - 32'd1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spw_engine.sv
module spw_engine #(
    parameter int FRAME_W = spw_pkg::FRAME_W,
    parameter int CNT_W   = spw_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               op_rd,
    input  logic [CNT_W-1:0]   nbits,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tick,
    input  logic               miso,
    output logic               busy,
    output logic               phase,
    output logic               mosi,
    output logic               done_wr,
    output logic               done_rd,
    output logic [FRAME_W-1:0] rx_word
);
    logic               is_rd;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   left;

    assign mosi = busy && !is_rd && sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            phase   <= 1'b0;
            is_rd   <= 1'b0;
            sh      <= '0;
            left    <= '0;
            rx_word <= '0;
            done_wr <= 1'b0;
            done_rd <= 1'b0;
        end else begin
            done_wr <= 1'b0;
            done_rd <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    phase <= 1'b0;
                    is_rd <= op_rd;
                    left  <= nbits;
                    sh    <= op_rd ? '0 : tx_word;
                    if (op_rd) rx_word <= '0;
                end
            end else if (tick) begin
                if (!phase) begin
                    // leave idle: sampling transition
                    phase <= 1'b1;
                    if (is_rd) rx_word <= {rx_word[FRAME_W-2:0], miso};
                end else begin
                    // return to idle: advance to next bit
                    phase <= 1'b0;
                    sh    <= {sh[FRAME_W-2:0], 1'b0};
                    left  <= left - 1'b1;
                    if (left == CNT_W'(1)) begin
                        busy    <= 1'b0;
                        done_wr <= !is_rd;
                        done_rd <= is_rd;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spw_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs,
    output logic              irq
);
    localparam int SLOT_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    cfga_t             cfga;
    cfgb_t             cfgb;
    logic [LEN_W-1:0]  len_m1;
    logic [SLOT_W-1:0] slot;
    logic              st_wr, st_rd;
    logic [DATA_W-1:0] tx_lo, tx_hi;
    logic [FRAME_W-1:0] rx_word;
    logic              busy, phase, tick, done_wr, done_rd;
    logic              ctrl_wr, start, irq_lvl, irq_lvl_q;
    reg_sel_e          sel;

    assign sel     = reg_sel_e'(reg_addr[3:1]);
    assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
    assign start   = ctrl_wr && !busy && (reg_wdata[0] || reg_wdata[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfga   <= '0;
            cfgb   <= '0;
            len_m1 <= '0;
            slot   <= '0;
            st_wr  <= 1'b0;
            st_rd  <= 1'b0;
            tx_lo  <= '0;
            tx_hi  <= '0;
        end else begin
            if (reg_wr) begin
                unique case (sel)
                    SEL_CFGA: cfga <= cfga_t'(reg_wdata[DIV_W+2:0]);
                    SEL_CFGB: cfgb <= '{pulse_irq: reg_wdata[10],
                                        cs_high:   reg_wdata[5],
                                        rise:      reg_wdata[0]};
                    SEL_CTRL: if (!busy) begin
                        len_m1 <= reg_wdata[6:2];
                        slot   <= reg_wdata[SLOT_LSB +: SLOT_W];
                    end
                    SEL_STAT: begin
                        st_wr <= st_wr & reg_wdata[1];
                        st_rd <= st_rd & reg_wdata[0];
                    end
                    SEL_TXL:  tx_lo <= reg_wdata;
                    SEL_TXH:  tx_hi <= reg_wdata;
                    default: ;
                endcase
            end
            // completion wins over a same-cycle clear
            if (done_wr) st_wr <= 1'b1;
            if (done_rd) st_rd <= 1'b1;
        end
    end

    spw_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && cfga.clk_en),
        .div  (cfga.div),
        .tick (tick)
    );

    spw_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_rd   (reg_wdata[0]),
        .nbits   (frame_bits(reg_wdata[6:2])),
        .tx_word ({tx_hi, tx_lo}),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .phase   (phase),
        .mosi    (spi_mosi),
        .done_wr (done_wr),
        .done_rd (done_rd),
        .rx_word (rx_word)
    );

    assign spi_sclk = !cfgb.rise ^ phase;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs[i] = (busy && (slot == SLOT_W'(i))) ? cfgb.cs_high : !cfgb.cs_high;
    end

    assign irq_lvl = (st_wr && cfga.ie_wr) || (st_rd && cfga.ie_rd);

    always_ff @(posedge clk) begin
        if (rst) irq_lvl_q <= 1'b0;
        else     irq_lvl_q <= irq_lvl;
    end

    assign irq = cfgb.pulse_irq ? (irq_lvl && !irq_lvl_q) : irq_lvl;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CFGA: reg_rdata[DIV_W+2:0] = cfga;
            SEL_CFGB: begin
                reg_rdata[10] = cfgb.pulse_irq;
                reg_rdata[5]  = cfgb.cs_high;
                reg_rdata[0]  = cfgb.rise;
            end
            SEL_CTRL: begin
                reg_rdata[6:2]                = len_m1;
                reg_rdata[SLOT_LSB +: SLOT_W] = slot;
            end
            SEL_STAT: reg_rdata[1:0] = {st_wr, st_rd};
            SEL_TXL:  reg_rdata = tx_lo;
            SEL_TXH:  reg_rdata = tx_hi;
            SEL_RXL:  reg_rdata = rx_word[DATA_W-1:0];
            SEL_RXH:  reg_rdata = rx_word[FRAME_W-1:DATA_W];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spw_chk.sv
module spw_chk #(
    parameter int NUM_CS = 2,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              clk_en,
    input logic              rise,
    input logic              cs_high,
    input logic              pulse_irq,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs,
    input logic              st_wr,
    input logic              st_rd,
    input logic              irq,
    input logic              ctrl_wr,
    input logic [LEN_W-1:0]  len_m1
);
    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && busy) |=> ($stable(sclk) || !$stable(rise)));

    // R7
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cs ^ {NUM_CS{!cs_high}}) <= 1);

    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs == {NUM_CS{!cs_high}}));

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == !rise));

    // R8
    done_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> (st_wr || st_rd));

    // R9
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> $stable(len_m1));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_irq && irq) |=> !(pulse_irq && irq));
endmodule

bind spi_word_master spw_chk #(.NUM_CS(NUM_CS), .LEN_W(spw_pkg::LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .clk_en    (cfga.clk_en),
    .rise      (cfgb.rise),
    .cs_high   (cfgb.cs_high),
    .pulse_irq (cfgb.pulse_irq),
    .sclk      (spi_sclk),
    .cs        (spi_cs),
    .st_wr     (st_wr),
    .st_rd     (st_rd),
    .irq       (irq),
    .ctrl_wr   (ctrl_wr),
    .len_m1    (len_m1)
);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
    localparam int NCS = 2;
    localparam logic [3:0] A_CFGA = 4'h0, A_CFGB = 4'h2, A_CTRL = 4'h4, A_STAT = 4'h6,
                           A_TXL = 4'h8, A_TXH = 4'hA, A_RXL = 4'hC, A_RXH = 4'hE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [NCS-1:0] spi_cs;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_word_master #(.NUM_CS(NCS)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs), .irq(irq)
    );

    // slave model: counters only grow; tasks take snapshots
    logic        rise_b = 1'b0;
    logic        lvl_b  = 1'b0;
    logic [31:0] pattern = '0;
    int          base = 0;
    logic        prev_sclk = 1'b1;
    logic [31:0] s_cap = '0;
    int          s_bits = 0, toggles = 0, cyc = 0, last_act = 0, period = 0;
    int          act0 = 0, act1 = 0, irq_cnt = 0;
    int          k_idx;

    assign k_idx    = s_bits - base;
    assign spi_miso = (k_idx >= 0 && k_idx < 32) ? pattern[31 - k_idx] : 1'b0;

    always @(negedge clk) begin
        cyc       <= cyc + 1;
        prev_sclk <= spi_sclk;
        if (irq) irq_cnt <= irq_cnt + 1;
        if (spi_cs[0] == lvl_b) act0 <= act0 + 1;
        if (spi_cs[1] == lvl_b) act1 <= act1 + 1;
        if (spi_sclk != prev_sclk && spi_cs != {NCS{!lvl_b}}) begin
            toggles <= toggles + 1;
            if (spi_sclk == rise_b) begin
                s_cap    <= {s_cap[30:0], spi_mosi};
                s_bits   <= s_bits + 1;
                period   <= cyc - last_act;
                last_act <= cyc;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input logic [1:0] mask, input string tag);
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd_reg(A_STAT, v);
            if ((v[1:0] & mask) != 0) return;
        end
        check(1'b0, {tag, " timeout"}, 0, mask);
    endtask

    task automatic do_op(input bit rd, input int len, input int dv, input bit edg,
                         input int slt, input bit lv, input logic [31:0] tx,
                         input logic [31:0] pat);
        int L, a0, a1;
        logic [15:0] v, h;
        longint mask;
        L = (len <= 8) ? 16 : len;
        mask = (64'd1 << L) - 1;
        rise_b = edg; lvl_b = lv; pattern = pat;
        wr_reg(A_CFGB, 16'(edg) | (16'(lv) << 5));
        wr_reg(A_CFGA, 16'(1 + (dv << 1)));
        wr_reg(A_TXL, tx[15:0]);
        wr_reg(A_TXH, tx[31:16]);
        repeat (2) @(negedge clk);
        base = s_bits; a0 = act0; a1 = act1;
        wr_reg(A_CTRL, 16'((slt << 7) | ((len - 1) << 2) | (rd ? 1 : 2)));
        wait_done(rd ? 2'b01 : 2'b10, rd ? "R4" : "R3");
        repeat (2) @(negedge clk);
        check(s_bits - base == L, rd ? "R4 bit count" : "R3 bit count", s_bits - base, L);
        if (!rd)
            check((longint'(s_cap) & mask) == longint'(tx >> (32 - L)), "R3 mosi data",
                  longint'(s_cap) & mask, longint'(tx >> (32 - L)));
        else begin
            rd_reg(A_RXL, v); rd_reg(A_RXH, h);
            check({h, v} == (pat >> (32 - L)), "R4 rx data", {h, v}, pat >> (32 - L));
        end
        check(period == (2 << dv), "R5 edge spacing", period, 2 << dv);
        check(((act0 != a0) == (slt == 0)) && ((act1 != a1) == (slt == 1)),
              "R7 slot select", {act1 != a1, act0 != a0}, 1 << slt);
        rd_reg(A_STAT, v);
        check(v == (rd ? 16'h1 : 16'h2), "R8 done flag", v, rd ? 1 : 2);
        wr_reg(A_STAT, 16'h0);
        rd_reg(A_STAT, v);
        check(v == 16'h0, "R8 clear", v, 0);
        wr_reg(A_CFGA, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int t0, b0, c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a += 2) begin
            rd_reg(4'(a), v);
            check(v == 16'h0, "R1 reset register", v, 0);
        end
        check(spi_cs == 2'b11 && spi_sclk == 1'b1 && irq == 1'b0, "R1 reset pins",
              {irq, spi_sclk, spi_cs}, 4'b0111);

        // R2 field layout readback
        wr_reg(A_CFGA, 16'hFFFF); rd_reg(A_CFGA, v);
        check(v == 16'h003F, "R2 config A fields", v, 16'h003F);
        wr_reg(A_CFGB, 16'hFFFF); rd_reg(A_CFGB, v);
        check(v == 16'h0421, "R2 config B fields", v, 16'h0421);
        wr_reg(A_CFGA, 16'h0); wr_reg(A_CFGB, 16'h0);
        wr_reg(A_TXH, 16'hBEEF); rd_reg(A_TXH, v);
        check(v == 16'hBEEF, "R2 tx high readback", v, 16'hBEEF);

        // R3 R4 R5 R7 R8 sweep over every length, both directions
        for (int len = 4; len <= 32; len++) begin
            for (int rd = 0; rd < 2; rd++) begin
                do_op(rd[0], len, len % 3, len[0] ^ rd[0], len[1], len[2],
                      32'hA5C3_0000 ^ (32'h9E37_79B9 * len),
                      32'h6B1D_4E27 ^ (32'h0101_0101 * len));
            end
        end

        // R6 clock enable freezes a word
        lvl_b = 1'b0; rise_b = 1'b1;
        wr_reg(A_CFGB, 16'h0001);
        wr_reg(A_CFGA, 16'h0000);
        wr_reg(A_TXH, 16'hF0F0);
        repeat (2) @(negedge clk);
        t0 = toggles; b0 = s_bits; base = s_bits;
        wr_reg(A_CTRL, 16'((15 << 2) | 2));
        repeat (100) @(negedge clk);
        rd_reg(A_STAT, v);
        check(toggles == t0 && v == 16'h0, "R6 frozen without enable", toggles - t0, 0);
        wr_reg(A_CFGA, 16'h0001);
        wait_done(2'b10, "R6");
        repeat (2) @(negedge clk);
        check(s_bits - b0 == 16, "R6 resumes to completion", s_bits - b0, 16);
        wr_reg(A_STAT, 16'h0);

        // R9 control write during a word is ignored
        wr_reg(A_CFGA, 16'h0005);
        b0 = s_bits;
        wr_reg(A_CTRL, 16'((31 << 2) | 2));
        wr_reg(A_CTRL, 16'((1 << 7) | (4 << 2) | 1));
        wait_done(2'b11, "R9");
        repeat (300) @(negedge clk);
        check(s_bits - b0 == 32, "R9 no second word", s_bits - b0, 32);
        rd_reg(A_CTRL, v);
        check(v == 16'h007C, "R9 control readback", v, 16'h007C);
        rd_reg(A_STAT, v);
        check(v == 16'h2, "R9 only write flagged", v, 2);
        wr_reg(A_STAT, 16'h0);

        // R8 selective clear: read then write, keep write flag only
        wr_reg(A_CFGA, 16'h0001);
        wr_reg(A_CTRL, 16'((15 << 2) | 1));
        wait_done(2'b01, "R8");
        wr_reg(A_CTRL, 16'((15 << 2) | 2));
        wait_done(2'b10, "R8");
        rd_reg(A_STAT, v);
        check(v == 16'h3, "R8 both flags", v, 3);
        wr_reg(A_STAT, 16'h2);
        rd_reg(A_STAT, v);
        check(v == 16'h2, "R8 partial clear", v, 2);
        wr_reg(A_STAT, 16'h0);

        // R10 level interrupt, enable gating, pulse style
        wr_reg(A_CFGA, 16'h0011);
        wr_reg(A_CTRL, 16'((15 << 2) | 2));
        wait_done(2'b10, "R10");
        @(negedge clk);
        check(irq == 1'b1, "R10 level irq on write done", irq, 1);
        wr_reg(A_STAT, 16'h0);
        @(negedge clk);
        check(irq == 1'b0, "R10 level irq cleared", irq, 0);
        wr_reg(A_CFGA, 16'h0021);
        wr_reg(A_CTRL, 16'((15 << 2) | 2));
        wait_done(2'b10, "R10");
        @(negedge clk);
        check(irq == 1'b0, "R10 irq masked by enable", irq, 0);
        wr_reg(A_STAT, 16'h0);
        wr_reg(A_CFGB, 16'h0400);
        c0 = irq_cnt;
        wr_reg(A_CTRL, 16'((15 << 2) | 1));
        wait_done(2'b01, "R10");
        repeat (10) @(negedge clk);
        check(irq_cnt - c0 == 1, "R10 single pulse", irq_cnt - c0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule